// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block runs once after reset and takes an SDRAM from power-on to a usable state. It holds the command bus at NOP, with clock enable and data mask high, for a startup pause. The pause is set in microseconds and converted to clocks from a clock-frequency parameter. It then issues a precharge of all banks and a mode register load that carries the programmed burst length, wrap type, CAS latency and write mode. It also issues a parameterised number of auto refresh commands, at least eight. A parameter places the refreshes before or after the mode load. Each command is followed by a wait, counted in clocks, before the next one. When the last wait has elapsed, `ready` rises and the command bus passes to the normal access controller.

The state machine has eight states. `ST_PAUSE` counts out the startup pause. `ST_PRECH` issues precharge-all and `ST_WAIT_RP` holds NOP for the precharge recovery. `ST_REFRESH` issues one auto refresh and `ST_WAIT_RC` holds NOP for the refresh cycle time. `ST_MODE` issues the mode load and `ST_WAIT_MRD` holds at least one NOP after it. `ST_READY` is terminal.

The transitions are as follows:
- pause expired: `ST_PAUSE` to `ST_PRECH`.
- precharge issued: `ST_PRECH` to `ST_WAIT_RP`.
- precharge recovered: `ST_WAIT_RP` to `ST_REFRESH` when refreshes come first, and to `ST_MODE` otherwise.
- refresh issued: `ST_REFRESH` to `ST_WAIT_RC`.
- refresh wait done with refreshes still owed: `ST_WAIT_RC` back to `ST_REFRESH`.
- refresh wait done with all refreshes issued: `ST_WAIT_RC` to `ST_MODE` when refreshes come first, and to `ST_READY` otherwise.
- mode load issued: `ST_MODE` to `ST_WAIT_MRD`.
- mode wait done: `ST_WAIT_MRD` to `ST_READY` when refreshes come first, and to `ST_REFRESH` otherwise.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset release, for PAUSE_US*CLK_MHZ cycles (cycles 0 to P-1), the bus carries NOP, with cke high and dqm high. NOP is {cs_n,ras_n,cas_n,we_n}=0111.
- R2: In cycle P the block issues precharge-all. This is command 0010 with addr[10]=1 and all other addr and ba bits 0. The next command follows exactly T_RP cycles later.
- R3: The mode load is command 0000 with ba=0. addr[2:0] holds log2 of the burst length, addr[3] is 1 for interleaved wrap, addr[6:4] holds the CAS latency, addr[9] is 1 for burst-read/single-write, and all other addr bits are 0.
- R4: The mode load is issued only after precharge-all, and cke has been high in every cycle before it.
- R5: After the mode load, the following cycle carries NOP. The next command, or ready, comes exactly T_MRD cycles after the mode load.
- R6: Exactly NUM_REFRESH auto refresh commands (0001, addr=0, ba=0) are issued, T_RC cycles apart.
- R7: With REFRESH_FIRST=1, all refreshes precede the mode load. With REFRESH_FIRST=0, all refreshes follow it.
- R8: Every cycle without a command carries NOP with addr=0 and ba=0. cke stays high at all times. dqm is high until ready and low from then on.
- R9: ready rises in the cycle after the wait of the last command expires, and stays high until reset.
- R10: Asserting reset at any point returns the outputs to the R1 state at once, and the whole sequence restarts on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus, carries the mode word and the precharge-all bit |
| dqm | output | 1 | Data mask, high until ready |
| ready | output | 1 | Initialization complete, sticky until reset |

## Verification
Every output is registered from the next state, so a command due in cycle k is visible from rising edge k up to edge k+1. The cycles fall at fixed points: precharge at P, the refreshes at fixed offsets spaced T_RC apart, the mode load at P+T_RP (or after the last refresh), and ready at the sum of all waits. The bench counts cycles from the reset release and computes these times arithmetically. It samples every port on the falling edge of every cycle and compares against that schedule, so any shift of one cycle is caught. Two instances cover both refresh placements and two mode words. A reset in mid-sequence is checked at once, in the same cycle.

// File: rtl/sdram_init_pkg.sv
`timescale 1ns/1ps
package sdram_init_pkg;

    // Command encoding {cs_n, ras_n, cas_n, we_n}
    typedef logic [3:0] sd_cmd_t;
    localparam sd_cmd_t CMD_NOP  = 4'b0111;
    localparam sd_cmd_t CMD_PRE  = 4'b0010;
    localparam sd_cmd_t CMD_REF  = 4'b0001;
    localparam sd_cmd_t CMD_MODE = 4'b0000;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_PRECH,
        ST_WAIT_RP,
        ST_REFRESH,
        ST_WAIT_RC,
        ST_MODE,
        ST_WAIT_MRD,
        ST_READY
    } init_state_t;

    function automatic logic [2:0] burst_code(input int len);
        case (len)
            8:       return 3'd3;
            4:       return 3'd2;
            2:       return 3'd1;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/init_wait_cnt.sv
`timescale 1ns/1ps
module init_wait_cnt #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R8: an idle, unexpired wait moves down by exactly one per clock
    a_r8_wait_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/init_mode_word.sv
`timescale 1ns/1ps
module init_mode_word
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int BURST_LEN    = 4,
    parameter int INTERLEAVE   = 0,
    parameter int CAS_LAT      = 3,
    parameter int SINGLE_WRITE = 0
) (
    output logic [ADDR_W-1:0] word_o
);
    // Field layout is decoded by the memory: [2:0] burst, [3] wrap, [6:4] latency, [9] write mode
    localparam logic [9:0] WORD = {1'(SINGLE_WRITE != 0), 2'b00, 3'(CAS_LAT),
                                   1'(INTERLEAVE != 0), burst_code(BURST_LEN)};

    assign word_o = ADDR_W'(WORD);

endmodule

// File: rtl/sdram_init_seq.sv
`timescale 1ns/1ps
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ       = 125,
    parameter int PAUSE_US      = 200,
    parameter int T_RP          = 3,
    parameter int T_RC          = 9,
    parameter int T_MRD         = 2,
    parameter int NUM_REFRESH   = 8,
    parameter int REFRESH_FIRST = 0,
    parameter int BURST_LEN     = 4,
    parameter int INTERLEAVE    = 0,
    parameter int CAS_LAT       = 3,
    parameter int SINGLE_WRITE  = 0,
    parameter int ADDR_W        = 12,
    parameter int BA_W          = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              dqm,
    output logic              ready
);
    // Waits T_* are >= 2 clocks; NUM_REFRESH >= 8; ADDR_W >= 11
    localparam int PAUSE_CLKS = CLK_MHZ * PAUSE_US;
    localparam int MAX_A      = (PAUSE_CLKS > T_RC) ? PAUSE_CLKS : T_RC;
    localparam int MAX_B      = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int MAX_WAIT   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W      = $clog2(MAX_WAIT + 1);
    localparam int RC_W       = $clog2(NUM_REFRESH + 2);
    localparam bit REF_FIRST  = (REFRESH_FIRST != 0);

    init_state_t      state_q, state_d;
    logic             wait_load, wait_done;
    logic [CNT_W-1:0] wait_val;
    logic [RC_W-1:0]  ref_cnt_q;
    logic             refs_done;
    logic [ADDR_W-1:0] mode_word;
    sd_cmd_t          cmd_q;

    init_mode_word #(
        .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN), .INTERLEAVE(INTERLEAVE),
        .CAS_LAT(CAS_LAT), .SINGLE_WRITE(SINGLE_WRITE)
    ) u_mode_word (
        .word_o(mode_word)
    );

    init_wait_cnt #(
        .CNT_W(CNT_W), .RST_VAL(PAUSE_CLKS - 1)
    ) u_wait (
        .clk(clk), .rst_n(rst_n), .load(wait_load),
        .load_val(wait_val), .expired(wait_done)
    );

    // Each command state arms the wait for the gap to the next command
    always_comb begin
        wait_load = 1'b1;
        unique case (state_q)
            ST_PRECH:   wait_val = CNT_W'(T_RP - 2);
            ST_REFRESH: wait_val = CNT_W'(T_RC - 2);
            ST_MODE:    wait_val = CNT_W'(T_MRD - 2);
            default: begin
                wait_load = 1'b0;
                wait_val  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     ref_cnt_q <= '0;
        else if (state_q == ST_REFRESH) ref_cnt_q <= ref_cnt_q + 1'b1;
    end

    assign refs_done = (ref_cnt_q == RC_W'(NUM_REFRESH));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PAUSE:    if (wait_done) state_d = ST_PRECH;
            ST_PRECH:    state_d = ST_WAIT_RP;
            ST_WAIT_RP:  if (wait_done) state_d = REF_FIRST ? ST_REFRESH : ST_MODE;
            ST_REFRESH:  state_d = ST_WAIT_RC;
            ST_WAIT_RC:  if (wait_done)
                             state_d = !refs_done ? ST_REFRESH
                                     : (REF_FIRST ? ST_MODE : ST_READY);
            ST_MODE:     state_d = ST_WAIT_MRD;
            ST_WAIT_MRD: if (wait_done) state_d = REF_FIRST ? ST_READY : ST_REFRESH;
            ST_READY:    state_d = ST_READY;
            default:     state_d = ST_PAUSE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PAUSE;
        else        state_q <= state_d;
    end

    // Outputs registered from the next state so they line up with state_q
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= CMD_NOP;
            addr  <= '0;
            ba    <= '0;
            cke   <= 1'b1;
            dqm   <= 1'b1;
            ready <= 1'b0;
        end else begin
            cmd_q <= CMD_NOP;
            addr  <= '0;
            ba    <= '0;
            cke   <= 1'b1;
            dqm   <= (state_d != ST_READY);
            ready <= (state_d == ST_READY);
            unique case (state_d)
                ST_PRECH: begin
                    cmd_q    <= CMD_PRE;
                    addr[10] <= 1'b1;
                end
                ST_REFRESH: cmd_q <= CMD_REF;
                ST_MODE: begin
                    cmd_q <= CMD_MODE;
                    addr  <= mode_word;
                end
                default: cmd_q <= CMD_NOP;
            endcase
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd_q;

    // Observation state for the ordering assertions
    logic            pre_seen_q;
    logic [RC_W-1:0] ref_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_seen_q <= 1'b0;
            ref_seen_q <= '0;
        end else begin
            if (cmd_q == CMD_PRE) pre_seen_q <= 1'b1;
            if (cmd_q == CMD_REF) ref_seen_q <= ref_seen_q + 1'b1;
        end
    end

    // R2: precharge always targets every bank
    a_r2_prech_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PRE) |-> addr[10]);

    // R4: mode load only after precharge and with clock enable held
    a_r4_mode_after_prech: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_MODE) |-> (pre_seen_q && cke && $past(cke)));

    // R5: mode load is followed by a NOP
    a_r5_nop_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_MODE) |=> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

    // R6: every refresh has been issued before ready appears
    a_r6_refresh_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (ref_seen_q == RC_W'(NUM_REFRESH)));

    // R9: ready is sticky until reset
    a_r9_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R8: mask released only together with ready
    a_r8_mask_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (dqm != ready) && cke);

endmodule

// File: tb/test_sdram_init_seq.sv
`timescale 1ns/1ps
module test_sdram_init_seq;

    localparam int CLK_MHZ = 1;
    localparam int PAUSE_US = 20;
    localparam int P = CLK_MHZ * PAUSE_US;
    localparam int T_RP = 3;
    localparam int T_RC = 5;
    localparam int T_MRD = 2;
    localparam int N_REF = 8;

    typedef struct packed {
        logic        cke;
        logic [3:0]  cmd;
        logic        dqm;
        logic        rdy;
        logic [1:0]  ba;
        logic [11:0] addr;
    } bus_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    logic a_cke, a_cs, a_ras, a_cas, a_we, a_dqm, a_rdy;
    logic [1:0] a_ba;
    logic [11:0] a_addr;
    logic b_cke, b_cs, b_ras, b_cas, b_we, b_dqm, b_rdy;
    logic [1:0] b_ba;
    logic [11:0] b_addr;

    // Instance A: refreshes after mode load, BL4 sequential CL3 normal writes
    sdram_init_seq #(
        .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .T_RP(T_RP), .T_RC(T_RC),
        .T_MRD(T_MRD), .NUM_REFRESH(N_REF), .REFRESH_FIRST(0),
        .BURST_LEN(4), .INTERLEAVE(0), .CAS_LAT(3), .SINGLE_WRITE(0)
    ) i_sdram_init_seq (
        .clk(clk), .rst_n(rst_n), .cke(a_cke), .cs_n(a_cs), .ras_n(a_ras),
        .cas_n(a_cas), .we_n(a_we), .ba(a_ba), .addr(a_addr), .dqm(a_dqm), .ready(a_rdy)
    );

    // Instance B: refreshes before mode load, BL8 interleaved CL2 single writes
    sdram_init_seq #(
        .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .T_RP(T_RP), .T_RC(T_RC),
        .T_MRD(T_MRD), .NUM_REFRESH(N_REF), .REFRESH_FIRST(1),
        .BURST_LEN(8), .INTERLEAVE(1), .CAS_LAT(2), .SINGLE_WRITE(1)
    ) i_sdram_init_seq_alt (
        .clk(clk), .rst_n(rst_n), .cke(b_cke), .cs_n(b_cs), .ras_n(b_ras),
        .cas_n(b_cas), .we_n(b_we), .ba(b_ba), .addr(b_addr), .dqm(b_dqm), .ready(b_rdy)
    );

    function automatic logic [11:0] mode_word(int bl, int il, int cl, int sw);
        return 12'($clog2(bl) + 8 * il + 16 * cl + 512 * sw);
    endfunction

    function automatic bus_t exp_bus(int cyc, bit rf, logic [11:0] word, output string tag);
        bus_t e;
        int mrs_t, ref_base, rdy_t;
        e = '{cke: 1'b1, cmd: 4'b0111, dqm: 1'b1, rdy: 1'b0, ba: 2'd0, addr: 12'd0};
        if (rf) begin
            ref_base = P + T_RP;
            mrs_t    = ref_base + N_REF * T_RC;
            rdy_t    = mrs_t + T_MRD;
        end else begin
            mrs_t    = P + T_RP;
            ref_base = mrs_t + T_MRD;
            rdy_t    = ref_base + N_REF * T_RC;
        end
        tag = (cyc < P) ? "R1" : "R8";
        if (cyc == P) begin
            e.cmd = 4'b0010; e.addr = 12'h400; tag = "R2";
        end else if (cyc == mrs_t) begin
            e.cmd = 4'b0000; e.addr = word; tag = "R3";
        end else if (cyc >= ref_base && (cyc - ref_base) % T_RC == 0
                     && (cyc - ref_base) / T_RC < N_REF) begin
            e.cmd = 4'b0001; tag = "R6";
        end
        if (cyc >= rdy_t) begin
            e.rdy = 1'b1; e.dqm = 1'b0;
        end
        return e;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_bus(string who, int cyc, bus_t act, bus_t exp, string tag);
        string ctag;
        ctag = (cyc < P) ? "R1" : "R8";
        check(tag, $sformatf("%s cyc%0d cmd", who, cyc), 32'(act.cmd), 32'(exp.cmd));
        check(tag, $sformatf("%s cyc%0d addr/ba", who, cyc), 32'({act.ba, act.addr}), 32'({exp.ba, exp.addr}));
        check(ctag, $sformatf("%s cyc%0d cke/dqm", who, cyc), 32'({act.cke, act.dqm}), 32'({exp.cke, exp.dqm}));
        check("R9", $sformatf("%s cyc%0d ready", who, cyc), 32'(act.rdy), 32'(exp.rdy));
    endtask

    bus_t a_bus, b_bus;
    assign a_bus = '{a_cke, {a_cs, a_ras, a_cas, a_we}, a_dqm, a_rdy, a_ba, a_addr};
    assign b_bus = '{b_cke, {b_cs, b_ras, b_cas, b_we}, b_dqm, b_rdy, b_ba, b_addr};

    logic [11:0] word_a, word_b;
    int a_refs, a_refs_pre_mrs, a_mrs_cyc, b_refs, b_refs_pre_mrs, b_mrs_cyc;
    bit a_pre, b_pre;

    task automatic track(int cyc);
        if (a_bus.cmd == 4'b0000) begin
            check("R4", "A mode load after precharge", 32'(a_pre), 32'd1);
            a_mrs_cyc = cyc; a_refs_pre_mrs = a_refs;
        end
        if (b_bus.cmd == 4'b0000) begin
            check("R4", "B mode load after precharge", 32'(b_pre), 32'd1);
            b_mrs_cyc = cyc; b_refs_pre_mrs = b_refs;
        end
        if (cyc == a_mrs_cyc + 1) check("R5", "A NOP after mode load", 32'(a_bus.cmd), 32'h7);
        if (cyc == b_mrs_cyc + 1) check("R5", "B NOP after mode load", 32'(b_bus.cmd), 32'h7);
        if (a_bus.cmd == 4'b0001) a_refs++;
        if (b_bus.cmd == 4'b0001) b_refs++;
        if (a_bus.cmd == 4'b0010) a_pre = 1'b1;
        if (b_bus.cmd == 4'b0010) b_pre = 1'b1;
    endtask

    task automatic run(int ncyc);
        string tag;
        bus_t e;
        a_refs = 0; b_refs = 0; a_pre = 0; b_pre = 0;
        a_mrs_cyc = -10; b_mrs_cyc = -10; a_refs_pre_mrs = -1; b_refs_pre_mrs = -1;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int cyc = 0; cyc < ncyc; cyc++) begin
            if (cyc > 0) @(negedge clk);
            e = exp_bus(cyc, 1'b0, word_a, tag);
            check_bus("A", cyc, a_bus, e, tag);
            e = exp_bus(cyc, 1'b1, word_b, tag);
            check_bus("B", cyc, b_bus, e, tag);
            track(cyc);
        end
    endtask

    initial begin
        word_a = mode_word(4, 0, 3, 0);
        word_b = mode_word(8, 1, 2, 1);
        repeat (3) @(negedge clk);
        check("R10", "A reset state", 32'(a_bus), 32'({1'b1, 4'b0111, 1'b1, 1'b0, 14'd0}));
        check("R10", "B reset state", 32'(b_bus), 32'({1'b1, 4'b0111, 1'b1, 1'b0, 14'd0}));
        // Partial run, then reset in mid-sequence
        run(P + T_RP + 6);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10", "A mid-sequence reset", 32'(a_bus), 32'({1'b1, 4'b0111, 1'b1, 1'b0, 14'd0}));
        check("R10", "B mid-sequence reset", 32'(b_bus), 32'({1'b1, 4'b0111, 1'b1, 1'b0, 14'd0}));
        repeat (2) @(negedge clk);
        // Full run, with ready held well past completion
        run(P + T_RP + T_MRD + N_REF * T_RC + 15);
        check("R6", "A refresh total", 32'(a_refs), 32'(N_REF));
        check("R6", "B refresh total", 32'(b_refs), 32'(N_REF));
        check("R7", "A refreshes before mode load", 32'(a_refs_pre_mrs), 32'd0);
        check("R7", "B refreshes before mode load", 32'(b_refs_pre_mrs), 32'(N_REF));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule